// File: doc/BRIEF.md
# Latency-Aware Recency Placement Controller

This block manages replacement and line placement for one eight-way set of a set-associative cache. The data arrays of that set are not equally fast: every way is tagged with an access latency class of one, two or three cycles. The controller keeps a 3-bit recency code per way, with 0 for the newest line and 7 for the oldest. It keeps that code in step with the latency class, so that the newest lines live in the quickest ways and the oldest line always lives in a slowest way.

When a lookup hits a slow way, the controller moves the hit line toward the fast ways. It issues one exchange command per faster latency class that is present, one command per cycle. It holds `busy` for the whole access. At the end it pulses `done` together with the number of cycles the access consumed. A fill on a miss writes into the way that holds code 7 (shown on `victim_way`) and then promotes the new line in the same way as a hit. The latency classes are loaded as one packed word, and each load rebuilds the recency codes from scratch.

Top module: `llru_ctrl`

## Requirements
- R1: After reset every way is class 1. Way w holds recency code w, `victim_way` is 7, and `busy` and `done` are low.
- R2: A load takes way w's class from `lat_table[2w+1:2w]`, with code 0 read as class 1. From the next cycle the code of way w equals the number of ways with a smaller class, plus the ways with an equal class and a lower index. A load produces no `done`.
- R3: After a hit or fill on the line with code r, that line holds code 0. Every line with a code below r gains one, and the other codes are unchanged. When idle, the codes form a permutation of 0..7 that never decreases with class.
- R4: The moving line makes one exchange for each present class faster than its own, from its current way to the way holding the highest code in the next faster present class. The exchanges appear one per cycle on `swap_valid`/`swap_src`/`swap_dst`, starting in the cycle after acceptance.
- R5: With L the class of the accessed way and s the number of exchanges, the access counts min(L+s, 2L) cycles. `busy` is high for exactly that many cycles after the accepting edge. `done` pulses in the following cycle, with that count on `done_cycles`. A hit in a class-1 way counts 1.
- R6: A fill uses the way that holds code 7, shown on `victim_way` while idle, and is then promoted exactly like a hit on code 7.
- R7: A lookup with `lookup_hit` low counts 1 cycle, makes no exchange and leaves the codes unchanged.
- R8: Loads and requests presented while `busy` is high are ignored. A request presented in the `done` cycle is accepted.
- R9: When several requests arrive together while idle, a load wins over a fill, and a fill wins over a lookup. The losers are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lat_load | input | 1 | Load the latency classes |
| lat_table | input | 16 | Two bits of class per way |
| lookup_req | input | 1 | Lookup request |
| lookup_hit | input | 1 | Lookup found the line |
| lookup_way | input | 3 | Way that hit |
| fill_req | input | 1 | Fill request after a miss |
| busy | output | 1 | Access in progress |
| swap_valid | output | 1 | Exchange command this cycle |
| swap_src | output | 3 | Way currently holding the moving line |
| swap_dst | output | 3 | Way it exchanges with |
| victim_way | output | 3 | Way holding code 7 |
| done | output | 1 | Access finished (one cycle) |
| done_cycles | output | 3 | Cycles consumed by the finished access |
| rank_vec | output | 24 | Recency code of each way, 3 bits per way |

## Verification
Two events can share a cycle: the `done` pulse of one access and the acceptance of the next request. The bench drives each operation in the very cycle the previous `done` is seen, so every access in the vector walk runs back to back. It then checks that the new access counts its cycles from that edge and still produces the expected exchanges and codes. A second overlap puts a load and a fill into the middle of a slow hit. The bench judges that case by the final codes, which must match a model in which neither intruder ever happened.

// File: rtl/llru_pkg.sv
package llru_pkg;
  localparam int LAT_W = 2;
  localparam int CYC_W = 3;

  // class code 0 is treated as the fastest class
  function automatic logic [LAT_W-1:0] lat_class(input logic [LAT_W-1:0] code);
    return (code == '0) ? LAT_W'(1) : code;
  endfunction

  // access cost: own latency plus one per exchange, never above twice the latency
  function automatic logic [CYC_W-1:0] access_cycles(input logic [LAT_W-1:0] lat,
                                                     input logic [LAT_W-1:0] nswap);
    logic [CYC_W-1:0] raw;
    logic [CYC_W-1:0] cap;
    raw = CYC_W'(lat) + CYC_W'(nswap);
    cap = CYC_W'({lat, 1'b0});
    return (raw > cap) ? cap : raw;
  endfunction
endpackage

// File: rtl/llru_lat_store.sv
module llru_lat_store
  import llru_pkg::*;
#(
  parameter int WAYS = 8,
  localparam int RW = $clog2(WAYS)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            load,
  input  logic [WAYS*LAT_W-1:0]           table_in,
  output logic [WAYS-1:0][LAT_W-1:0]      lat_q,
  output logic [WAYS-1:0][RW-1:0]         seed_rank
);
  // seed code: count of ways ahead in (class, index) order (R2)
  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      int cnt;
      logic [LAT_W-1:0] lw;
      cnt = 0;
      lw  = lat_class(table_in[w*LAT_W +: LAT_W]);
      for (int j = 0; j < WAYS; j++) begin
        logic [LAT_W-1:0] lj;
        lj = lat_class(table_in[j*LAT_W +: LAT_W]);
        if (lj < lw || (lj == lw && j < w)) cnt++;
      end
      seed_rank[w] = RW'(cnt);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < WAYS; w++) lat_q[w] <= LAT_W'(1);
    end else if (load) begin
      for (int w = 0; w < WAYS; w++) lat_q[w] <= lat_class(table_in[w*LAT_W +: LAT_W]);
    end
  end
endmodule

// File: rtl/llru_route.sv
module llru_route
  import llru_pkg::*;
#(
  parameter int WAYS = 8,
  localparam int RW = $clog2(WAYS)
) (
  input  logic [WAYS-1:0][LAT_W-1:0] lat_q,
  input  logic [WAYS-1:0][RW-1:0]    rank_q,
  input  logic [RW-1:0]              probe,
  output logic [RW-1:0]              dst,
  output logic [LAT_W-1:0]           nfaster,
  output logic [RW-1:0]              victim
);
  logic [3:0]       present;
  logic [LAT_W-1:0] cls;
  logic [LAT_W-1:0] tgt;
  logic [RW-1:0]    best;
  logic             found;

  always_comb begin
    present = '0;
    for (int w = 0; w < WAYS; w++) present[lat_q[w]] = 1'b1;
    cls     = lat_q[probe];
    nfaster = '0;
    tgt     = '0;
    for (int k = 1; k <= 3; k++) begin
      if (LAT_W'(k) < cls && present[k]) begin
        nfaster = nfaster + LAT_W'(1);
        tgt     = LAT_W'(k);
      end
    end
    // partner: oldest line of the next faster present class (R4)
    dst   = probe;
    best  = '0;
    found = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (lat_q[w] == tgt && (!found || rank_q[w] > best)) begin
        dst   = RW'(w);
        best  = rank_q[w];
        found = 1'b1;
      end
    end
    victim = '0;
    for (int w = 0; w < WAYS; w++)
      if (rank_q[w] == RW'(WAYS-1)) victim = RW'(w);
  end
endmodule

// File: rtl/llru_ctrl.sv
module llru_ctrl
  import llru_pkg::*;
#(
  parameter int WAYS = 8,
  localparam int RW = $clog2(WAYS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    lat_load,
  input  logic [WAYS*LAT_W-1:0]   lat_table,
  input  logic                    lookup_req,
  input  logic                    lookup_hit,
  input  logic [RW-1:0]           lookup_way,
  input  logic                    fill_req,
  output logic                    busy,
  output logic                    swap_valid,
  output logic [RW-1:0]           swap_src,
  output logic [RW-1:0]           swap_dst,
  output logic [RW-1:0]           victim_way,
  output logic                    done,
  output logic [CYC_W-1:0]        done_cycles,
  output logic [WAYS*RW-1:0]      rank_vec
);
  logic [WAYS-1:0][LAT_W-1:0] lat_q;
  logic [WAYS-1:0][RW-1:0]    seed_rank;
  logic [WAYS-1:0][RW-1:0]    rank_q;
  logic [RW-1:0]              probe, dst, victim, start_way, cur_q, hitrank_q;
  logic [LAT_W-1:0]           nfaster, nswap_q, step_q;
  logic [CYC_W-1:0]           rem_q, total_q, cyc_q, start_cycles;
  logic                       busy_q, done_q, upd_q;

  // named events for the checker
  logic accept, do_load, do_fill, do_look, start_upd, swap_fire, finish;

  assign accept    = !busy_q;
  assign do_load   = accept && lat_load;                            // R9
  assign do_fill   = accept && !lat_load && fill_req;
  assign do_look   = accept && !lat_load && !fill_req && lookup_req;
  assign start_upd = do_fill || (do_look && lookup_hit);
  assign start_way = do_fill ? victim : lookup_way;                 // R6
  assign probe     = busy_q ? cur_q : start_way;
  assign start_cycles = start_upd ? access_cycles(lat_q[start_way], nfaster)
                                  : CYC_W'(1);                      // R7
  assign swap_fire = busy_q && (step_q < nswap_q);
  assign finish    = busy_q && (rem_q == CYC_W'(1));

  llru_lat_store #(.WAYS(WAYS)) u_store (
    .clk(clk), .rst_n(rst_n), .load(do_load), .table_in(lat_table),
    .lat_q(lat_q), .seed_rank(seed_rank)
  );

  llru_route #(.WAYS(WAYS)) u_route (
    .lat_q(lat_q), .rank_q(rank_q), .probe(probe),
    .dst(dst), .nfaster(nfaster), .victim(victim)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < WAYS; w++) rank_q[w] <= RW'(w);   // R1
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      upd_q     <= 1'b0;
      rem_q     <= '0;
      total_q   <= '0;
      cyc_q     <= '0;
      step_q    <= '0;
      nswap_q   <= '0;
      cur_q     <= '0;
      hitrank_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (do_load) begin
        rank_q <= seed_rank;
      end else if (do_fill || do_look) begin
        busy_q    <= 1'b1;
        rem_q     <= start_cycles;
        total_q   <= start_cycles;
        step_q    <= '0;
        nswap_q   <= start_upd ? nfaster : '0;
        cur_q     <= start_way;
        hitrank_q <= rank_q[start_way];
        upd_q     <= start_upd;
      end
      if (busy_q) begin
        rem_q <= rem_q - CYC_W'(1);
        if (swap_fire) begin                                   // R4
          rank_q[cur_q] <= rank_q[dst];
          rank_q[dst]   <= rank_q[cur_q];
          cur_q         <= dst;
          step_q        <= step_q + LAT_W'(1);
        end
        if (finish) begin                                      // R5
          busy_q <= 1'b0;
          done_q <= 1'b1;
          cyc_q  <= total_q;
          if (upd_q) begin                                     // R3
            for (int w = 0; w < WAYS; w++) begin
              if (rank_q[w] == hitrank_q)     rank_q[w] <= '0;
              else if (rank_q[w] < hitrank_q) rank_q[w] <= rank_q[w] + RW'(1);
            end
          end
        end
      end
    end
  end

  assign busy        = busy_q;
  assign swap_valid  = swap_fire;
  assign swap_src    = cur_q;
  assign swap_dst    = dst;
  assign victim_way  = victim;
  assign done        = done_q;
  assign done_cycles = cyc_q;
  assign rank_vec    = rank_q;
endmodule

// File: rtl/llru_ctrl_chk.sv
module llru_ctrl_chk #(
  parameter int WAYS = 8,
  localparam int RW = $clog2(WAYS)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               busy,
  input logic               done,
  input logic [2:0]         done_cycles,
  input logic               swap_valid,
  input logic [RW-1:0]      swap_src,
  input logic [RW-1:0]      swap_dst,
  input logic [RW-1:0]      victim_way,
  input logic [WAYS*RW-1:0] rank_vec
);
  function automatic logic [RW-1:0] code_of(input logic [WAYS*RW-1:0] v, input logic [RW-1:0] w);
    return v[w*RW +: RW];
  endfunction

  function automatic logic all_distinct(input logic [WAYS*RW-1:0] v);
    logic [WAYS-1:0] seen;
    seen = '0;
    for (int w = 0; w < WAYS; w++) seen[v[w*RW +: RW]] = 1'b1;
    return &seen;
  endfunction

  p_swap_in_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    swap_valid |-> busy);
  p_swap_to_newer_r4: assert property (@(posedge clk) disable iff (!rst_n)
    swap_valid |-> (code_of(rank_vec, swap_dst) < code_of(rank_vec, swap_src)));
  p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_after_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  p_done_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (done_cycles >= 3'd1 && done_cycles <= 3'd6));
  p_idle_perm_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> all_distinct(rank_vec));
  p_victim_oldest_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (code_of(rank_vec, victim_way) == RW'(WAYS-1)));
endmodule

bind llru_ctrl llru_ctrl_chk #(.WAYS(WAYS)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .done_cycles(done_cycles),
  .swap_valid(swap_valid), .swap_src(swap_src), .swap_dst(swap_dst),
  .victim_way(victim_way), .rank_vec(rank_vec)
);

// File: tb/test_llru_ctrl.sv
module test_llru_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lat_load = 1'b0;
  logic [15:0] lat_table = '0;
  logic        lookup_req = 1'b0;
  logic        lookup_hit = 1'b0;
  logic [2:0]  lookup_way = '0;
  logic        fill_req = 1'b0;
  logic        busy, swap_valid, done;
  logic [2:0]  swap_src, swap_dst, victim_way, done_cycles;
  logic [23:0] rank_vec;

  int total = 0;
  int bad   = 0;
  int m_lat [8];
  int m_rank[8];

  always #10 clk = ~clk;

  llru_ctrl i_llru_ctrl (
    .clk(clk), .rst_n(rst_n), .lat_load(lat_load), .lat_table(lat_table),
    .lookup_req(lookup_req), .lookup_hit(lookup_hit), .lookup_way(lookup_way),
    .fill_req(fill_req), .busy(busy), .swap_valid(swap_valid), .swap_src(swap_src),
    .swap_dst(swap_dst), .victim_way(victim_way), .done(done),
    .done_cycles(done_cycles), .rank_vec(rank_vec)
  );

  // op: 0 load, 1 hit, 2 lookup without hit, 3 fill ; {op, way, table}
  localparam int NV = 16;
  localparam logic [20:0] VEC [NV] = '{
    {2'd0, 3'd0, 16'hB676}, {2'd1, 3'd6, 16'h0}, {2'd1, 3'd0, 16'h0}, {2'd3, 3'd0, 16'h0},
    {2'd2, 3'd2, 16'h0},    {2'd1, 3'd1, 16'h0}, {2'd3, 3'd0, 16'h0}, {2'd3, 3'd0, 16'h0},
    {2'd1, 3'd2, 16'h0},    {2'd0, 3'd0, 16'hFFFC}, {2'd1, 3'd7, 16'h0}, {2'd3, 3'd0, 16'h0},
    {2'd1, 3'd0, 16'h0},    {2'd0, 3'd0, 16'h9E4B}, {2'd1, 3'd4, 16'h0}, {2'd3, 3'd0, 16'h0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rk(input int w);
    return int'(rank_vec[w*3 +: 3]);
  endfunction

  task automatic model_load(input logic [15:0] tbl);
    for (int w = 0; w < 8; w++) begin
      m_lat[w] = int'(tbl[2*w +: 2]);
      if (m_lat[w] == 0) m_lat[w] = 1;
    end
    for (int w = 0; w < 8; w++) begin
      m_rank[w] = 0;
      for (int j = 0; j < 8; j++)
        if (m_lat[j] < m_lat[w] || (m_lat[j] == m_lat[w] && j < w)) m_rank[w]++;
    end
  endtask

  task automatic check_codes(input string tag);
    bit mono;
    bit [7:0] seen;
    mono = 1'b1;
    seen = '0;
    for (int w = 0; w < 8; w++) begin
      chk(rk(w) == m_rank[w], tag, rk(w), m_rank[w]);
      seen[rk(w)] = 1'b1;
      for (int j = 0; j < 8; j++)
        if (m_lat[j] < m_lat[w] && rk(j) > rk(w)) mono = 1'b0;
    end
    chk(seen == 8'hFF && mono, "R3 permutation/monotonic", int'(seen), 255);
  endtask

  // called at a negedge; intrude adds a load and a fill during busy (R8)
  task automatic run_op(input int op, input int way, input logic [15:0] tbl, input bit intrude);
    int es_src[4];
    int es_dst[4];
    int ns, r, lw, cur, exp_cyc, n, got;
    if (op == 0) begin
      lat_load = 1'b1; lat_table = tbl;
      @(negedge clk);
      lat_load = 1'b0;
      model_load(tbl);
      check_codes("R2 seeded code");
      chk(!busy && !done, "R2 load has no access", int'(busy) + int'(done), 0);
      return;
    end
    if (op == 3) begin
      for (int w = 0; w < 8; w++) if (m_rank[w] == 7) way = w;
      chk(int'(victim_way) == way, "R6 victim way", int'(victim_way), way);
    end
    ns = 0;
    if (op == 2) exp_cyc = 1;
    else begin
      lw = m_lat[way]; r = m_rank[way]; cur = way;
      for (int k = lw - 1; k >= 1; k--) begin
        int d;
        d = -1;
        for (int w = 0; w < 8; w++)
          if (m_lat[w] == k && (d < 0 || m_rank[w] > m_rank[d])) d = w;
        if (d >= 0) begin
          int t;
          es_src[ns] = cur; es_dst[ns] = d;
          t = m_rank[cur]; m_rank[cur] = m_rank[d]; m_rank[d] = t;
          cur = d; ns++;
        end
      end
      for (int w = 0; w < 8; w++) begin
        if (m_rank[w] == r) m_rank[w] = 0;
        else if (m_rank[w] < r) m_rank[w]++;
      end
      exp_cyc = (lw + ns > 2 * lw) ? 2 * lw : lw + ns;
    end
    lookup_req = (op != 3); lookup_hit = (op == 1); lookup_way = 3'(way);
    fill_req = (op == 3);
    n = 0; got = 0;
    while (n < 40) begin
      @(negedge clk);
      n++;
      if (n == 1) begin
        lookup_req = 1'b0; fill_req = 1'b0;
        chk(busy, "R5 busy after accept", int'(busy), 1);
        if (intrude) begin lat_load = 1'b1; lat_table = 16'h5555; fill_req = 1'b1; end
      end else if (n == 2) begin
        lat_load = 1'b0; fill_req = 1'b0;
      end
      if (swap_valid) begin
        if (got < ns) begin
          chk(int'(swap_src) == es_src[got], "R4 swap source", int'(swap_src), es_src[got]);
          chk(int'(swap_dst) == es_dst[got], "R4 swap dest", int'(swap_dst), es_dst[got]);
        end
        got++;
      end
      if (done) break;
    end
    chk(n - 1 == exp_cyc, "R5 cycles to done", n - 1, exp_cyc);
    chk(int'(done_cycles) == exp_cyc, "R5 reported count", int'(done_cycles), exp_cyc);
    chk(got == ns, (op == 2) ? "R7 no swaps on miss" : "R4 swap count", got, ns);
    check_codes(op == 2 ? "R7 codes unchanged" : (intrude ? "R8 intrusion ignored" : "R3 codes after access"));
  endtask

  initial begin
    #(20 * 100000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    model_load(16'h0000);
    check_codes("R1 reset codes");
    chk(victim_way == 3'd7, "R1 reset victim", int'(victim_way), 7);
    chk(!busy && !done, "R1 reset idle", int'(busy) + int'(done), 0);

    for (int i = 0; i < NV; i++) begin
      logic [20:0] v;
      v = VEC[i];
      run_op(int'(v[20:19]), int'(v[18:16]), v[15:0], 1'b0);
    end

    // R8: load and fill arrive in the middle of a slow hit
    run_op(0, 0, 16'hB676, 1'b0);
    run_op(1, 2, 16'h0, 1'b1);

    // R9: load, fill and lookup together while idle: only the load acts
    lat_load = 1'b1; lat_table = 16'h5555; fill_req = 1'b1;
    lookup_req = 1'b1; lookup_hit = 1'b1; lookup_way = 3'd5;
    @(negedge clk);
    lat_load = 1'b0; fill_req = 1'b0; lookup_req = 1'b0;
    model_load(16'h5555);
    chk(!busy, "R9 load wins, no access", int'(busy), 0);
    check_codes("R9 codes from load");
    @(negedge clk);
    chk(!done, "R9 no done from dropped request", int'(done), 0);

    // R5/R6: all-fast set, fill costs one cycle
    run_op(3, 0, 16'h0, 1'b0);
    run_op(1, 6, 16'h0, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule